// File: doc/BRIEF.md
# Beeper Bit to Sample Stretcher

This block turns a one-bit speaker port into an 8-bit audio sample stream when the processor that drives that port only runs for a short part of each video frame. Each write to the port stores a level bit. On line ticks that fall inside the blanking window, the stored bit is pushed into a small buffer, together with a flag that says whether the port was written since the last push. Every line tick plays one buffered entry, and each entry is held for four ticks. This spreads a burst gathered over the blanking lines across the whole frame.

When a played entry carries a written flag, the output goes to full scale low or high. When there was no write, or the buffer has nothing left to play, the output moves in fixed steps back toward mid-scale. This keeps a silent beeper from leaving a DC offset that would thump in an amplified speaker. A frame-start pulse empties the buffer for the next frame. The block feeds an external DAC.

Top module: `beeper_stretcher`

## Requirements
- R1: Under synchronous reset (rstN low at a clock edge) the sample output becomes the rest level 0x80, the buffer is empty and no port write is pending.
- R2: A port write stores portBit and marks the port as written. Of several writes between two captures only the last bit counts. A write in the same cycle as a capture belongs to the next capture.
- R3: A capture happens only on a line tick with blankFlag high and no frame start. It stores the stored bit and the written mark, then clears the mark. At most DEPTH (default 160) captures are taken per frame, and blank ticks beyond that are dropped.
- R4: Each line tick without frame start plays the oldest unplayed entry when one exists. Each entry is played on REPEAT (default 4) consecutive playing ticks before the next entry is used.
- R5: Playing an entry whose written mark is set makes the output 0xFF for bit 1 or 0x00 for bit 0, visible in the cycle after the tick.
- R6: Playing an entry with no written mark, or a tick with nothing to play, moves the output 8 codes toward 0x80 and never past it (for example 0x84 goes to 0x80 and 0x00 goes to 0x08).
- R7: Once every captured entry has been played, playback stops and only the decay continues. An entry captured on a tick is not played before the following tick.
- R8: A frame start empties the buffer and clears the repeat count. A line tick in the same cycle is ignored, and the output and the stored port bit are kept.
- R9: The output changes only in the cycle after a line tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWrEn | input | 1 | Speaker port write strobe |
| portBit | input | 1 | Speaker level carried by the write |
| lineTick | input | 1 | One-cycle pulse per video line |
| blankFlag | input | 1 | High while the line is in the blanking window |
| frameStart | input | 1 | One-cycle pulse at the start of a frame |
| sampleOut | output | 8 | Unsigned audio sample, rest level 0x80 |

## Verification
Every result is registered once. A port write, a capture and a played sample all take effect at the edge that samples the strobe. The new sample is visible from the next cycle until the next tick. The bench drives inputs on the falling edge and advances its model by exactly that one edge. It then compares sampleOut on the next falling edge in every cycle, so a change that comes one cycle early or late, or on a cycle with no tick, is reported. Directed frames cover buffer overflow, running empty, frames with no writes, and a frame start that coincides with a tick. Random frames mix writes and bits.

// File: rtl/beeper_pkg.sv
package beeper_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic tick;
    logic capture;
    logic play;
    logic advance;
  } ctlStrobe_t;

  // one buffer slot
  typedef struct packed {
    logic level;
    logic written;
  } beepEntry_t;

endpackage

// File: rtl/beeper_ctl.sv
module beeper_ctl
  import beeper_pkg::*;
#(
  parameter int DEPTH  = 160,
  parameter int REPEAT = 4,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineTick,
  input  logic          blankFlag,
  input  logic          frameStart,
  output ctlStrobe_t    strobe,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr
);

  logic [RW-1:0] repCnt;
  logic          tickOk;

  always_comb begin
    tickOk         = lineTick && !frameStart;
    strobe.flush   = frameStart;
    strobe.tick    = tickOk;
    strobe.capture = tickOk && blankFlag && (wrPtr < PW'(DEPTH));
    strobe.play    = tickOk && (rdPtr < wrPtr);
    strobe.advance = strobe.play && (repCnt == RW'(REPEAT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      repCnt <= '0;
    end else if (strobe.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      repCnt <= '0;
    end else begin
      if (strobe.capture) wrPtr <= wrPtr + 1'b1;
      if (strobe.play) begin
        if (strobe.advance) begin
          repCnt <= '0;
          rdPtr  <= rdPtr + 1'b1;
        end else begin
          repCnt <= repCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/beeper_dp.sv
module beeper_dp
  import beeper_pkg::*;
#(
  parameter int         DEPTH = 160,
  parameter int         SW    = 8,
  parameter logic [7:0] REST  = 8'h80,
  parameter logic [7:0] LOW   = 8'h00,
  parameter logic [7:0] HIGH  = 8'hFF,
  parameter logic [7:0] STEP  = 8'd8,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          portWrEn,
  input  logic          portBit,
  input  ctlStrobe_t    strobe,
  input  logic [PW-1:0] wrPtr,
  input  logic [PW-1:0] rdPtr,
  output logic [SW-1:0] sampleOut
);

  beepEntry_t entryMem [DEPTH];
  beepEntry_t headEntry;
  logic       latchBit;
  logic       wroteFlag;
  logic [AW-1:0] wrIdx;
  logic [AW-1:0] rdIdx;
  logic [SW-1:0] decayed;

  // step toward rest, never past it
  function automatic logic [SW-1:0] towardRest(input logic [SW-1:0] cur);
    if (cur > SW'(REST)) begin
      return ((cur - SW'(REST)) > SW'(STEP)) ? cur - SW'(STEP) : SW'(REST);
    end else if (cur < SW'(REST)) begin
      return ((SW'(REST) - cur) > SW'(STEP)) ? cur + SW'(STEP) : SW'(REST);
    end
    return cur;
  endfunction

  always_comb begin
    wrIdx     = AW'(wrPtr);
    rdIdx     = (rdPtr < PW'(DEPTH)) ? AW'(rdPtr) : '0;
    headEntry = entryMem[rdIdx];
    decayed   = towardRest(sampleOut);
  end

  // port latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchBit  <= 1'b0;
      wroteFlag <= 1'b0;
    end else begin
      if (strobe.capture) wroteFlag <= 1'b0;
      if (portWrEn) begin
        latchBit  <= portBit;
        wroteFlag <= 1'b1;
      end
    end
  end

  // buffer storage
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      entryMem[wrIdx] <= '{level: latchBit, written: wroteFlag};
    end
  end

  // sample register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= SW'(REST);
    end else if (strobe.tick) begin
      if (strobe.play && headEntry.written) begin
        sampleOut <= headEntry.level ? SW'(HIGH) : SW'(LOW);
      end else begin
        sampleOut <= decayed;
      end
    end
  end

endmodule

// File: rtl/beeper_stretcher.sv
module beeper_stretcher
  import beeper_pkg::*;
#(
  parameter int         DEPTH  = 160,
  parameter int         REPEAT = 4,
  parameter logic [7:0] REST   = 8'h80,
  parameter logic [7:0] STEP   = 8'd8,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portWrEn,
  input  logic       portBit,
  input  logic       lineTick,
  input  logic       blankFlag,
  input  logic       frameStart,
  output logic [7:0] sampleOut
);

  ctlStrobe_t    strobe;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  beeper_ctl #(.DEPTH(DEPTH), .REPEAT(REPEAT)) u_ctl (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .blankFlag(blankFlag),
    .frameStart(frameStart), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  beeper_dp #(.DEPTH(DEPTH), .SW(8), .REST(REST), .LOW(8'h00),
              .HIGH(8'hFF), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portBit(portBit),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .sampleOut(sampleOut)
  );

endmodule

// File: rtl/beeper_stretcher_chk.sv
module beeper_stretcher_chk #(
  parameter int         DEPTH = 160,
  parameter logic [7:0] REST  = 8'h80,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          lineTick,
  input logic          blankFlag,
  input logic          frameStart,
  input logic [7:0]    sampleOut,
  input logic [PW-1:0] wrPtr,
  input logic [PW-1:0] rdPtr
);

  function automatic logic [7:0] distRest(input logic [7:0] v);
    return (v >= REST) ? v - REST : REST - v;
  endfunction

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!lineTick || frameStart) |=> $stable(sampleOut)); // R9

  AST_TOWARD_REST: assert property (@(posedge clk) disable iff (!rstN)
    lineTick |=> (sampleOut == 8'h00 || sampleOut == 8'hFF ||
                  distRest(sampleOut) <= distRest($past(sampleOut)))); // R6

  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= wrPtr); // R7

  AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PW'(DEPTH)); // R3

  AST_NO_CAPTURE_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !(lineTick && blankFlag)) |=> $stable(wrPtr)); // R3

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (wrPtr == '0 && rdPtr == '0)); // R8

endmodule

bind beeper_stretcher beeper_stretcher_chk #(.DEPTH(DEPTH), .REST(REST)) u_chk (
  .clk(clk), .rstN(rstN), .lineTick(lineTick), .blankFlag(blankFlag),
  .frameStart(frameStart), .sampleOut(sampleOut), .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/beeper_stretcher_bench.sv
`timescale 1ns/1ps
module beeper_stretcher_bench;

  localparam int DEPTH  = 160;
  localparam int REPEAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portWrEn = 1'b0, portBit = 1'b0, lineTick = 1'b0;
  logic blankFlag = 1'b0, frameStart = 1'b0;
  logic [7:0] sampleOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;
  string curTag  = "R1";

  // reference state
  logic       mLev  [DEPTH];
  logic       mWrit [DEPTH];
  int         mWrP, mRdP, mRep;
  logic [7:0] mOut;
  logic       mLatch, mWrote;

  always #2 clk = ~clk;

  beeper_stretcher u_beeper_stretcher (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portBit(portBit),
    .lineTick(lineTick), .blankFlag(blankFlag), .frameStart(frameStart),
    .sampleOut(sampleOut)
  );

  function automatic logic [7:0] decay(input logic [7:0] v);
    if (v > 8'h80) return (v - 8'h80 > 8) ? v - 8'd8 : 8'h80;
    if (v < 8'h80) return (8'h80 - v > 8) ? v + 8'd8 : 8'h80;
    return v;
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: sampleOut actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelStep(input logic we, input logic b, input logic tk,
                           input logic bl, input logic fs);
    logic oldLatch, oldWrote;
    oldLatch = mLatch;
    oldWrote = mWrote;
    if (fs) begin
      mWrP = 0; mRdP = 0; mRep = 0;                  // R8
    end else if (tk) begin
      if (mRdP < mWrP) begin                         // R4
        if (mWrit[mRdP]) mOut = mLev[mRdP] ? 8'hFF : 8'h00;  // R5
        else mOut = decay(mOut);
        if (mRep == REPEAT - 1) begin mRep = 0; mRdP++; end
        else mRep++;
      end else begin
        mOut = decay(mOut);                          // R6 R7
      end
      if (bl && mWrP < DEPTH) begin                  // R3
        mLev[mWrP] = oldLatch; mWrit[mWrP] = oldWrote;
        mWrP++; mWrote = 1'b0;
      end
    end
    if (we) begin mLatch = b; mWrote = 1'b1; end     // R2
  endtask

  task automatic cycle(input logic we, input logic b, input logic tk,
                       input logic bl, input logic fs);
    portWrEn = we; portBit = b; lineTick = tk; blankFlag = bl; frameStart = fs;
    modelStep(we, b, tk, bl, fs);
    @(posedge clk);
    @(negedge clk);
    check(sampleOut, mOut, curTag);
  endtask

  // one frame: frame start, then nTicks ticks spaced by gap cycles
  task automatic runFrame(input int nTicks, input int blankTicks, input int gap,
                          input int wrPct);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int t = 0; t < nTicks; t++) begin
      for (int g = 0; g < gap - 1; g++) begin
        cycle(($urandom % 100) < wrPct, $urandom % 2, 1'b0, t < blankTicks, 1'b0);
      end
      cycle(($urandom % 100) < wrPct / 2, $urandom % 2, 1'b1, t < blankTicks, 1'b0);
    end
  endtask

  initial begin
    #150000;
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    mWrP = 0; mRdP = 0; mRep = 0; mOut = 8'h80; mLatch = 0; mWrote = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sampleOut, 8'h80, "R1");                  // R1 reset level
    rstN = 1'b1;
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 1, 0, 0);                            // R1 empty buffer: decay only
    // R2: several writes, last wins; write on capture tick goes to next
    curTag = "R2";
    cycle(0, 0, 0, 0, 1);
    cycle(1, 1, 0, 1, 0); cycle(1, 0, 0, 1, 0); cycle(1, 1, 0, 1, 0);
    cycle(1, 0, 1, 1, 0);                            // captures 1, latches 0
    cycle(0, 0, 1, 1, 0);                            // captures 0 written
    cycle(0, 0, 1, 1, 0);                            // captures unwritten
    for (int i = 0; i < 14; i++) begin cycle(0, 0, 0, 0, 0); cycle(0, 0, 1, 0, 0); end
    // R5: playing levels
    curTag = "R5";
    runFrame(40, 8, 2, 60);
    // R7: short burst then empty
    curTag = "R7";
    runFrame(60, 3, 3, 80);
    // R6: no writes at all after a full-scale level
    curTag = "R6";
    cycle(0, 0, 0, 0, 1); cycle(1, 1, 1, 1, 0);
    cycle(0, 0, 1, 1, 0);
    runFrame(40, 20, 2, 0);
    // R3: blank window longer than the buffer
    curTag = "R3";
    runFrame(200, 180, 2, 40);
    // R8: frame start coinciding with a tick mid-frame
    curTag = "R8";
    runFrame(30, 30, 2, 50);
    cycle(1, 1, 1, 1, 1);
    for (int i = 0; i < 20; i++) cycle(0, 0, 1, 1, 0);
    // R9: idle cycles hold output
    curTag = "R9";
    for (int i = 0; i < 10; i++) cycle($urandom % 2, $urandom % 2, 0, 1, 0);
    // R4: random full frames
    curTag = "R4";
    for (int f = 0; f < 4; f++) runFrame(525, 140, 3, 30);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule